// File: doc/BRIEF.md
# Priority Interrupt Collector with Nesting

The collector takes up to 64 interrupt request lines and drives one registered IRQ line toward a processor. Every source owns a small setting field with a two-bit priority level, an enable and a software-forced request. Among the sources that are pending, the block chooses one winner. It publishes the winner's number and a vector address, which is a programmable base plus four times that number.

Software reaches the block over a simple word-addressed register port. Every register can be written at four alias offsets: base+0x0 replaces the register, base+0x4 sets the written bits, base+0x8 clears them and base+0xC toggles them. The service routine marks its interrupt as in service in one of two ways. In one mode it writes the vector register. In the other mode the read of the vector register does this as a side effect. The block records the level of each interrupt in service. When the routine finishes, it writes a per-level acknowledge to release that level. Nesting lets a strictly higher level interrupt a running routine. Nesting can also be switched off completely.

The vector base register sits just after the per-source setting words, at 0x60 + (NUM_SRC/4)*0x10. That is 0x160 for 64 sources.

Top module: `intc_collector`

## Requirements
- R1: Each register accepts writes at four aliases chosen by address bits [3:2]: 0 replaces the value, 1 ORs the data in, 2 clears the bits set in the data, and 3 XORs the data in. A read at any alias returns the register.
- R2: Setting word k, at byte offset 0x60 + k*0x10, holds sources 4k to 4k+3, one byte each, with source 4k in the lowest byte. Inside a byte, bits [1:0] are the priority level (3 is the highest), bit 2 is the enable and bit 3 is the software request. Bits [7:4] of every byte read as zero.
- R3: Offset 0x40 reads request lines 31..0 and offset 0x50 reads lines 63..32, both live and without side effects.
- R4: A source is pending only when its enable bit is 1 and either its line or its software request bit is 1.
- R5: Among pending sources, the highest level wins. On equal levels, the lowest source number wins.
- R6: Offset 0x30 reads the presented vector number in bits [5:0]. The vector register at 0x00 reads base + 4*number. The base register keeps bits [31:2] of what is written, and bits [1:0] read as zero.
- R7: Control bit 16 enables the IRQ output. irq_o is registered, so it reflects a state change at the second falling edge after the write, not the first.
- R8: When control bit 18 is 0, a write to the vector register puts the winner's level in service. A read of the vector register changes nothing.
- R9: When control bit 18 is 1, a read of the vector register puts the winner's level in service.
- R10: Writing 1 to bit L of the acknowledge register at 0x10 clears the in-service state of level L. Reading 0x10 returns the in-service bits, one per level.
- R11: With nesting allowed (control bit 19 = 0), irq_o is raised only when the winner's level is above every level in service.
- R12: With control bit 19 = 1, irq_o stays low while any level is in service.
- R13: From the moment a source goes in service until the next acknowledge write with a nonzero mask, the presented vector number stays frozen, even if the winner changes.
- R14: A synchronous active-low reset clears all settings, the control bits, the base, the in-service bits and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src_i | input | NUM_SRC | Raw interrupt request lines |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W-2 | Word address (byte address bits [ADDR_W-1:2]) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the block with its defaults: 64 sources and a 12-bit address. With 64 sources, both raw-view words and all sixteen setting words exist, so the table of arbitration cases can place winners at source 0, source 63 and across the word and half boundaries. The 12-bit address leaves room for the base register after the setting words. The directed part walks one service sequence through both in-service modes and through nesting on and off. At each step it reads the acknowledge register, so the in-service state is observed at the port.

// File: rtl/intc_pkg.sv
package intc_pkg;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_SET   = 2'd1,
      OP_CLR   = 2'd2,
      OP_TOG   = 2'd3
   } alias_op_e;

   // register indices (byte address bits [ADDR_W-1:4])
   localparam int IDX_VEC  = 0;
   localparam int IDX_ACK  = 1;
   localparam int IDX_CTRL = 2;
   localparam int IDX_STAT = 3;
   localparam int IDX_RAW0 = 4;
   localparam int IDX_SRC0 = 6;

   // control bit positions
   localparam int CTRL_IRQ_EN  = 16;
   localparam int CTRL_RD_MODE = 18;
   localparam int CTRL_NO_NEST = 19;

   function automatic logic [31:0] apply_op(input alias_op_e op,
                                            input logic [31:0] cur,
                                            input logic [31:0] wd);
      case (op)
         OP_WRITE: return wd;
         OP_SET:   return cur | wd;
         OP_CLR:   return cur & ~wd;
         default:  return cur ^ wd;
      endcase
   endfunction

endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
   parameter int NUM_SRC = 64,
   parameter int LVL_W   = 2,
   localparam int VEC_W  = $clog2(NUM_SRC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       pend_i,
   input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
   output logic                     valid_o,
   output logic [VEC_W-1:0]         win_idx_o,
   output logic [LVL_W-1:0]         win_lvl_o
);

   generate
      if (NUM_SRC < 2) begin : g_bad_src
         $error("intc_arbiter: NUM_SRC must be at least 2");
      end
   endgenerate

   // scan from the top index down; >= lets a lower index take over on a tie
   always_comb begin
      valid_o   = 1'b0;
      win_idx_o = '0;
      win_lvl_o = '0;
      for (int n = NUM_SRC - 1; n >= 0; n--) begin
         if (pend_i[n] && (!valid_o || lvl_i[n*LVL_W +: LVL_W] >= win_lvl_o)) begin
            valid_o   = 1'b1;
            win_idx_o = VEC_W'(n);
            win_lvl_o = lvl_i[n*LVL_W +: LVL_W];
         end
      end
   end

   // R5: a winner is always a pending source
   p_win_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> pend_i[win_idx_o]);

endmodule

// File: rtl/intc_level_track.sv
module intc_level_track #(
   parameter int LEVELS = 4,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en_i,
   input  logic [LVL_W-1:0]  set_lvl_i,
   input  logic [LEVELS-1:0] ack_mask_i,
   input  logic              no_nest_i,
   input  logic [LVL_W-1:0]  cand_lvl_i,
   output logic [LEVELS-1:0] insvc_o,
   output logic              gate_o
);

   generate
      if (LEVELS < 2 || (1 << LVL_W) != LEVELS) begin : g_bad_lvl
         $error("intc_level_track: LEVELS must be a power of two >= 2");
      end
   endgenerate

   logic [LEVELS-1:0] insvc_q;
   logic [LEVELS-1:0] set_mask;
   logic [LVL_W-1:0]  top_lvl;
   logic              any_busy;

   always_comb begin
      set_mask = '0;
      if (set_en_i) set_mask[set_lvl_i] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) insvc_q <= '0;
      else        insvc_q <= (insvc_q & ~ack_mask_i) | set_mask;
   end

   always_comb begin
      top_lvl = '0;
      for (int l = 0; l < LEVELS; l++)
         if (insvc_q[l]) top_lvl = LVL_W'(l);
   end

   assign any_busy = |insvc_q;
   assign gate_o   = no_nest_i ? !any_busy : (!any_busy || cand_lvl_i > top_lvl);
   assign insvc_o  = insvc_q;

   // R8: in-service bits only appear after an in-service event
   p_set_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !set_en_i |=> ((insvc_q & ~$past(insvc_q)) == '0));

   // R10: acknowledged levels are released
   p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_mask_i != '0 && !set_en_i) |=> ((insvc_q & $past(ack_mask_i)) == '0));

endmodule

// File: rtl/intc_collector.sv
module intc_collector #(
   parameter int NUM_SRC = 64,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_src_i,
   input  logic               bus_sel_i,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:2]  bus_addr_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   output logic               irq_o
);
   import intc_pkg::*;

   localparam int LVL_W     = 2;
   localparam int LEVELS    = 1 << LVL_W;
   localparam int VEC_W     = $clog2(NUM_SRC);
   localparam int SRC_WORDS = NUM_SRC / 4;
   localparam int RAW_WORDS = NUM_SRC / 32;
   localparam int IDX_W     = ADDR_W - 4;
   localparam int IDX_BASE  = IDX_SRC0 + SRC_WORDS;

   generate
      if (NUM_SRC % 32 != 0 || NUM_SRC < 32 || NUM_SRC > 64) begin : g_bad_num
         $error("intc_collector: NUM_SRC must be 32 or 64");
      end
      if ((1 << IDX_W) <= IDX_BASE) begin : g_bad_addr
         $error("intc_collector: ADDR_W too small for the register map");
      end
   endgenerate

   // ---------------- decode ----------------
   logic [IDX_W-1:0] idx;
   alias_op_e        op;
   logic             wr_hit, rd_hit;

   assign idx    = bus_addr_i[ADDR_W-1:4];
   assign op     = alias_op_e'(bus_addr_i[3:2]);
   assign wr_hit = bus_sel_i & bus_wr_i;
   assign rd_hit = bus_sel_i & ~bus_wr_i;

   // ---------------- per-source settings ----------------
   logic [NUM_SRC*4-1:0]      cfg_flat;
   logic [SRC_WORDS*32-1:0]   src_word_flat;
   logic [NUM_SRC-1:0]        pend;
   logic [NUM_SRC*LVL_W-1:0]  lvl_flat;

   generate
      for (genvar w = 0; w < SRC_WORDS; w++) begin : g_word
         logic [15:0] nib_q;
         logic [31:0] word_cur, word_new;

         always_comb begin
            for (int k = 0; k < 4; k++)
               word_cur[8*k +: 8] = {4'b0, nib_q[4*k +: 4]};
            word_new = apply_op(op, word_cur, bus_wdata_i);
         end

         always_ff @(posedge clk) begin
            if (!rst_n) nib_q <= '0;
            else if (wr_hit && idx == IDX_W'(IDX_SRC0 + w))
               for (int k = 0; k < 4; k++)
                  nib_q[4*k +: 4] <= word_new[8*k +: 4];
         end

         assign cfg_flat[16*w +: 16]      = nib_q;
         assign src_word_flat[32*w +: 32] = word_cur;
      end

      for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
         assign pend[n] = cfg_flat[4*n+2] & (irq_src_i[n] | cfg_flat[4*n+3]);
         assign lvl_flat[LVL_W*n +: LVL_W] = cfg_flat[4*n +: LVL_W];
      end
   endgenerate

   // ---------------- control and base ----------------
   logic        irq_en_q, rd_mode_q, no_nest_q;
   logic [31:2] base_q;
   logic [31:0] ctrl_cur, ctrl_new, base_new;

   always_comb begin
      ctrl_cur = '0;
      ctrl_cur[CTRL_IRQ_EN]  = irq_en_q;
      ctrl_cur[CTRL_RD_MODE] = rd_mode_q;
      ctrl_cur[CTRL_NO_NEST] = no_nest_q;
      ctrl_new = apply_op(op, ctrl_cur, bus_wdata_i);
      base_new = apply_op(op, {base_q, 2'b00}, bus_wdata_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en_q  <= 1'b0;
         rd_mode_q <= 1'b0;
         no_nest_q <= 1'b0;
         base_q    <= '0;
      end else if (wr_hit) begin
         if (idx == IDX_W'(IDX_CTRL)) begin
            irq_en_q  <= ctrl_new[CTRL_IRQ_EN];
            rd_mode_q <= ctrl_new[CTRL_RD_MODE];
            no_nest_q <= ctrl_new[CTRL_NO_NEST];
         end
         if (idx == IDX_W'(IDX_BASE)) base_q <= base_new[31:2];
      end
   end

   // ---------------- arbitration ----------------
   logic             win_valid;
   logic [VEC_W-1:0] win_idx;
   logic [LVL_W-1:0] win_lvl;

   intc_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_i    (pend),
      .lvl_i     (lvl_flat),
      .valid_o   (win_valid),
      .win_idx_o (win_idx),
      .win_lvl_o (win_lvl)
   );

   // ---------------- in-service tracking ----------------
   logic              vec_hit, go_svc, set_en, ack_hit, gate;
   logic [LEVELS-1:0] ack_mask, insvc;

   assign vec_hit  = (idx == IDX_W'(IDX_VEC));
   assign go_svc   = vec_hit & (rd_mode_q ? rd_hit : wr_hit);
   assign set_en   = go_svc & win_valid;
   assign ack_mask = (wr_hit && idx == IDX_W'(IDX_ACK)) ? bus_wdata_i[LEVELS-1:0] : '0;
   assign ack_hit  = |ack_mask;

   intc_level_track #(.LEVELS(LEVELS)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_en_i   (set_en),
      .set_lvl_i  (win_lvl),
      .ack_mask_i (ack_mask),
      .no_nest_i  (no_nest_q),
      .cand_lvl_i (win_lvl),
      .insvc_o    (insvc),
      .gate_o     (gate)
   );

   // ---------------- presented vector ----------------
   logic             frozen_q;
   logic [VEC_W-1:0] held_q, cur_vec;
   logic [31:0]      vec_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frozen_q <= 1'b0;
         held_q   <= '0;
      end else if (set_en) begin
         frozen_q <= 1'b1;
         held_q   <= win_idx;
      end else if (ack_hit) begin
         frozen_q <= 1'b0;
      end
   end

   assign cur_vec  = frozen_q ? held_q : win_idx;
   assign vec_addr = {base_q, 2'b00} + (32'(cur_vec) << 2);

   // ---------------- IRQ output ----------------
   logic irq_q;
   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_en_q & win_valid & gate;
   end
   assign irq_o = irq_q;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata_o = '0;
      if (idx == IDX_W'(IDX_VEC))  bus_rdata_o = vec_addr;
      if (idx == IDX_W'(IDX_ACK))  bus_rdata_o = 32'(insvc);
      if (idx == IDX_W'(IDX_CTRL)) bus_rdata_o = ctrl_cur;
      if (idx == IDX_W'(IDX_STAT)) bus_rdata_o = 32'(cur_vec);
      if (idx == IDX_W'(IDX_BASE)) bus_rdata_o = {base_q, 2'b00};
      for (int r = 0; r < RAW_WORDS; r++)
         if (idx == IDX_W'(IDX_RAW0 + r)) bus_rdata_o = irq_src_i[32*r +: 32];
      for (int w = 0; w < SRC_WORDS; w++)
         if (idx == IDX_W'(IDX_SRC0 + w)) bus_rdata_o = src_word_flat[32*w +: 32];
   end

   // R7: output stays low while globally disabled
   p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_q |=> !irq_o);

   // R12: no request while a level is busy and nesting is off
   p_nonest_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (no_nest_q && insvc != '0) |=> !irq_o);

   // R13: frozen vector holds until acknowledge or a new in-service event
   p_vec_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_q && !set_en && !ack_hit) |=> $stable(cur_vec));

endmodule

// File: tb/intc_collector_tb.sv
`timescale 1ns/1ps
module intc_collector_tb;

   localparam logic [11:0] A_VEC  = 12'h000;
   localparam logic [11:0] A_ACK  = 12'h010;
   localparam logic [11:0] A_CTRL = 12'h020;
   localparam logic [11:0] A_STAT = 12'h030;
   localparam logic [11:0] A_RAW0 = 12'h040;
   localparam logic [11:0] A_RAW1 = 12'h050;
   localparam logic [11:0] A_SRC  = 12'h060;
   localparam logic [11:0] A_BASE = 12'h160;

   // {src_a, lvl_a, src_b, lvl_b, expected winner}
   localparam logic [39:0] TBL [6] = '{
      {8'd5,  8'd1, 8'd9,  8'd3, 8'd9},
      {8'd12, 8'd2, 8'd3,  8'd2, 8'd3},
      {8'd63, 8'd3, 8'd0,  8'd0, 8'd63},
      {8'd40, 8'd1, 8'd41, 8'd1, 8'd40},
      {8'd33, 8'd0, 8'd7,  8'd0, 8'd7},
      {8'd20, 8'd3, 8'd50, 8'd2, 8'd20}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src = '0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [11:2] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int total = 0, bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   intc_collector u_dut (
      .clk(clk), .rst_n(rst_n), .irq_src_i(src),
      .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a[11:2]; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a[11:2];
      #1 d = rdata;
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic src_set(input int n, input int lvl, input bit en, input bit sw);
      logic [11:0] a;
      int sh;
      a  = A_SRC + 12'((n >> 2) * 16);
      sh = 8 * (n % 4);
      wr_reg(a + 12'h8, 32'hF << sh);
      wr_reg(a + 12'h4, {28'b0, sw, en, 2'(lvl)} << sh);
   endtask

   task automatic clr_src();
      for (int w = 0; w < 16; w++) wr_reg(A_SRC + 12'(w * 16), 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R14 reset state
      chk("R14 irq", {31'b0, irq}, 0);
      rd_reg(A_CTRL, d); chk("R14 ctrl", d, 0);
      rd_reg(A_ACK, d);  chk("R14 insvc", d, 0);
      rd_reg(A_BASE, d); chk("R14 base", d, 0);
      rd_reg(A_SRC, d);  chk("R14 cfg", d, 0);

      // R1 alias operations
      wr_reg(A_BASE,        32'hF0F0_0000); rd_reg(A_BASE, d); chk("R1 write", d, 32'hF0F0_0000);
      wr_reg(A_BASE + 12'h4, 32'h0000_FF00); rd_reg(A_BASE, d); chk("R1 set", d, 32'hF0F0_FF00);
      wr_reg(A_BASE + 12'h8, 32'hF000_0F00); rd_reg(A_BASE + 12'hC, d); chk("R1 clr", d, 32'h00F0_F000);
      wr_reg(A_BASE + 12'hC, 32'h0FF0_0000); rd_reg(A_BASE, d); chk("R1 tog", d, 32'h0F00_F000);
      wr_reg(A_BASE, 32'h0000_1003); rd_reg(A_BASE, d); chk("R6 base low bits", d, 32'h0000_1000);

      // R2 field layout
      wr_reg(A_SRC + 12'h10, 32'hFFFF_FFFF); rd_reg(A_SRC + 12'h10, d); chk("R2 readback", d, 32'h0F0F_0F0F);
      wr_reg(A_SRC + 12'h10, 32'h0);

      // R3 raw view
      src = 64'hDEAD_BEEF_0123_4567;
      rd_reg(A_RAW0, d); chk("R3 raw0", d, 32'h0123_4567);
      rd_reg(A_RAW1, d); chk("R3 raw1", d, 32'hDEAD_BEEF);
      src = '0;

      // R5 / R6 arbitration table
      for (int i = 0; i < 6; i++) begin
         clr_src();
         src_set(int'(TBL[i][39:32]), int'(TBL[i][31:24]), 1'b1, 1'b1);
         src_set(int'(TBL[i][23:16]), int'(TBL[i][15:8]),  1'b1, 1'b1);
         rd_reg(A_STAT, d); chk("R5 winner", d, 32'(TBL[i][7:0]));
         rd_reg(A_VEC, d);  chk("R6 vector", d, 32'h1000 + 32'(TBL[i][7:0]) * 4);
      end
      clr_src();

      // R4 pending needs enable, R7 one-cycle lag
      wr_reg(A_CTRL, 32'h0001_0000);
      src[17] = 1'b1;
      src_set(17, 1, 1'b0, 1'b0);
      settle(); settle();
      chk("R4 disabled line", {31'b0, irq}, 0);
      src_set(17, 1, 1'b1, 1'b0);
      chk("R7 lag", {31'b0, irq}, 0);
      settle();
      chk("R7 raised", {31'b0, irq}, 1);

      // R8 mode 0: read has no effect, write goes in service
      rd_reg(A_VEC, d); chk("R6 vec addr", d, 32'h1044);
      rd_reg(A_ACK, d); chk("R8 read ignored", d, 0);
      wr_reg(A_VEC, 32'h0);
      rd_reg(A_ACK, d); chk("R8 in service", d, 32'h2);
      chk("R11 same level gated", {31'b0, irq}, 0);

      // R11 nesting
      src_set(20, 0, 1'b1, 1'b1);
      settle();
      chk("R11 lower level gated", {31'b0, irq}, 0);
      src_set(30, 3, 1'b1, 1'b1);
      settle();
      chk("R11 higher level nests", {31'b0, irq}, 1);
      rd_reg(A_STAT, d); chk("R13 frozen at 17", d, 17);
      wr_reg(A_VEC, 32'h0);
      rd_reg(A_ACK, d); chk("R11 two levels", d, 32'hA);
      rd_reg(A_STAT, d); chk("R13 relatch 30", d, 30);

      // R10 acknowledge
      wr_reg(A_ACK, 32'h8);
      rd_reg(A_ACK, d); chk("R10 release lvl3", d, 32'h2);
      src_set(30, 0, 1'b0, 1'b0);
      wr_reg(A_ACK, 32'h2);
      rd_reg(A_ACK, d); chk("R10 release lvl1", d, 0);
      settle();
      chk("R7 irq after ack", {31'b0, irq}, 1);

      // R13 freeze against a new lower-index winner
      wr_reg(A_VEC, 32'h0);
      src_set(2, 1, 1'b1, 1'b1);
      rd_reg(A_STAT, d); chk("R13 held", d, 17);
      wr_reg(A_ACK, 32'h2);
      rd_reg(A_STAT, d); chk("R13 released", d, 2);

      // R12 nesting disabled
      wr_reg(A_CTRL, 32'h0009_0000);
      wr_reg(A_VEC, 32'h0);
      src_set(40, 3, 1'b1, 1'b1);
      settle();
      chk("R12 blocked", {31'b0, irq}, 0);
      wr_reg(A_ACK, 32'h2);
      settle();
      chk("R12 after ack", {31'b0, irq}, 1);

      // R9 read side effect mode
      wr_reg(A_CTRL, 32'h0005_0000);
      rd_reg(A_VEC, d); chk("R9 vec addr", d, 32'h10A0);
      rd_reg(A_ACK, d); chk("R9 read in service", d, 32'h8);
      wr_reg(A_ACK, 32'h8);

      // R14 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      settle(); settle();
      rst_n = 1'b1;
      chk("R14 irq after reset", {31'b0, irq}, 0);
      rd_reg(A_CTRL, d); chk("R14 ctrl after reset", d, 0);
      rd_reg(A_BASE, d); chk("R14 base after reset", d, 0);
      rd_reg(A_SRC + 12'h90, d); chk("R14 cfg after reset", d, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule